// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit is the saturating arithmetic slice of a 32-bit integer pipeline. Each cycle it can accept one operation. The operation has two register operands (A and B), an immediate field and a 3-bit operation code. It produces a destination value meant for register B and updates a small flag set: zero, sign, carry, overflow and a sticky saturation flag. Signed overflow does not wrap the destination value. Instead the value is clamped to the most positive or the most negative two's-complement number. The zero and sign flags still describe the wrapped, unclamped result, so software can see what the raw arithmetic did.

Five forms are supported. Two are additions: A plus B, and a sign-extended short immediate plus B. Three are subtractions: B minus A, B minus a sign-extended long immediate, and the reverse form A minus B. The saturation flag works as an accumulator. An operation can only set it. Only the separate clear input removes it, so a long sequence of operations can be checked once at the end.

All outputs are registered. They change on the rising edge that samples a valid strobe with a legal code, and they hold at every other time.

Top module: `sat_arith_unit`

## Requirements
- R1: One cycle after `valid_i` is high with a legal code, `result_o` holds the non-overflowing result. The codes are: 0 = B+A, 1 = B+sext(imm[4:0]), 2 = B−A, 3 = B−sext(imm[15:0]), 4 = A−B.
- R2: On an addition, overflow is detected when both operands have the same sign bit and the wrapped sum's sign bit differs from it. On overflow the result is 0x80000000 if the first operand (A or the immediate) is negative, and 0x7FFFFFFF otherwise.
- R3: On a subtraction, overflow is detected when minuend and subtrahend differ in sign and the wrapped difference's sign differs from the minuend's. On overflow the result is 0x80000000 if the minuend is negative, and 0x7FFFFFFF otherwise.
- R4: `zero_o` and `sign_o` are taken from the wrapped, unclamped 32-bit result. Zero is high when that result is all zeros. Sign is its bit 31.
- R5: For an addition, `carry_o` is the unsigned carry out of bit 31. For a subtraction, `carry_o` is an unsigned borrow: it is high when the subtrahend is greater than the minuend as unsigned values.
- R6: Every accepted operation rewrites `ovf_o`. It is high exactly when that operation overflowed.
- R7: `sat_o` is set by any accepted overflowing operation and is never cleared by an operation. Only `sat_clr_i` clears it. If the clear and an overflowing operation occur in the same cycle, the flag ends up set.
- R8: When `valid_i` is low, or the code is 5, 6 or 7, `result_o` and the zero, sign, carry and overflow flags keep their values. `sat_clr_i` still acts.
- R9: While `rst_ni` is low, every output is zero.
- R10: Code 1 uses only `imm_i[4:0]`, sign-extended, and ignores `imm_i[15:5]`. Code 3 uses all 16 bits of `imm_i`, sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (see R1) |
| reg_a_i | input | 32 | Register operand A |
| reg_b_i | input | 32 | Register operand B (also the destination) |
| imm_i | input | 16 | Immediate field |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| result_o | output | 32 | Value to be written back to register B |
| zero_o | output | 1 | Wrapped result is zero |
| sign_o | output | 1 | Bit 31 of the wrapped result |
| carry_o | output | 1 | Carry (add) or borrow (subtract) |
| ovf_o | output | 1 | Last accepted operation overflowed |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The hardest situations to reach are at the boundaries of the signed range. Random 32-bit operands almost never land exactly on the wrap point, and they never exercise the sign-extended immediate limits. The stimulus therefore applies the operands directly. These include the largest positive value plus one, the most negative value minus one, a reverse subtract of minus one from the maximum, a short immediate of −16 with junk in the ignored upper bits, and a long immediate of 0x8000. Sticky behaviour needs an ordered sequence: overflow, then clean operations, then a standalone clear, then a clear that coincides with an overflow. The bench scripts that sequence and follows it with a random mix that includes illegal codes and idle cycles.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

   typedef enum logic [2:0] {
      OP_ADD_RR  = 3'd0,
      OP_ADD_IS  = 3'd1,
      OP_SUB_RR  = 3'd2,
      OP_SUB_IL  = 3'd3,
      OP_RSUB_RR = 3'd4
   } sa_op_e;

   typedef struct packed {
      logic z;
      logic s;
      logic cy;
      logic ov;
   } sa_flags_t;

endpackage

// File: rtl/sa_imm_ext.sv
module sa_imm_ext #(
   parameter int IN_W  = 5,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  imm_i,
   output logic [OUT_W-1:0] ext_o
);
   localparam int PAD_W = OUT_W - IN_W;

   initial begin : chk_widths
      if (IN_W < 1 || IN_W >= OUT_W)
         $fatal(1, "sa_imm_ext: IN_W must be in 1..OUT_W-1");
   end

   assign ext_o = {{PAD_W{imm_i[IN_W-1]}}, imm_i};
endmodule

// File: rtl/sa_operand_mux.sv
module sa_operand_mux
   import sat_arith_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] reg_a_i,
   input  logic [DATA_W-1:0] reg_b_i,
   input  logic [DATA_W-1:0] simm_i,
   input  logic [DATA_W-1:0] limm_i,
   output logic [DATA_W-1:0] x_o,
   output logic [DATA_W-1:0] y_o,
   output logic              is_sub_o,
   output logic              legal_o
);
   // x is the sign-deciding operand: first addend or minuend.
   always_comb begin
      x_o      = reg_a_i;
      y_o      = reg_b_i;
      is_sub_o = 1'b0;
      legal_o  = 1'b1;
      case (sa_op_e'(op_i))
         OP_ADD_RR:  begin x_o = reg_a_i; y_o = reg_b_i; end
         OP_ADD_IS:  begin x_o = simm_i;  y_o = reg_b_i; end
         OP_SUB_RR:  begin x_o = reg_b_i; y_o = reg_a_i; is_sub_o = 1'b1; end
         OP_SUB_IL:  begin x_o = reg_b_i; y_o = limm_i;  is_sub_o = 1'b1; end
         OP_RSUB_RR: begin x_o = reg_a_i; y_o = reg_b_i; is_sub_o = 1'b1; end
         default:    legal_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/sa_addsub_core.sv
module sa_addsub_core
   import sat_arith_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              is_sub_i,
   output logic [DATA_W-1:0] raw_o,
   output logic [DATA_W-1:0] sat_res_o,
   output sa_flags_t         flags_o
);
   localparam int                MSB     = DATA_W - 1;
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   logic cy;
   logic ov;

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder: subtraction as x + ~y + 1, borrow is inverted carry.
         logic [DATA_W-1:0] y_eff;
         logic [DATA_W:0]   sum;
         assign y_eff = is_sub_i ? ~y_i : y_i;
         assign sum   = {1'b0, x_i} + {1'b0, y_eff} + {{DATA_W{1'b0}}, is_sub_i};
         assign raw_o = sum[MSB:0];
         assign cy    = is_sub_i ? ~sum[DATA_W] : sum[DATA_W];
         assign ov    = (x_i[MSB] == y_eff[MSB]) && (sum[MSB] != x_i[MSB]);
      end else begin : g_split
         // Two parallel paths, selected at the end.
         logic [DATA_W:0] add_w;
         logic [DATA_W:0] sub_w;
         logic            add_ov;
         logic            sub_ov;
         assign add_w  = {1'b0, x_i} + {1'b0, y_i};
         assign sub_w  = {1'b0, x_i} - {1'b0, y_i};
         assign add_ov = (x_i[MSB] == y_i[MSB]) && (add_w[MSB] != x_i[MSB]);
         assign sub_ov = (x_i[MSB] != y_i[MSB]) && (sub_w[MSB] != x_i[MSB]);
         assign raw_o  = is_sub_i ? sub_w[MSB:0] : add_w[MSB:0];
         assign cy     = is_sub_i ? sub_w[DATA_W] : add_w[DATA_W];
         assign ov     = is_sub_i ? sub_ov : add_ov;
      end
   endgenerate

   assign sat_res_o  = ov ? (x_i[MSB] ? NEG_MIN : POS_MAX) : raw_o;
   assign flags_o.z  = (raw_o == '0);
   assign flags_o.s  = raw_o[MSB];
   assign flags_o.cy = cy;
   assign flags_o.ov = ov;
endmodule

// File: rtl/sa_status_reg.sv
module sa_status_reg
   import sat_arith_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic              sat_clr_i,
   input  logic [DATA_W-1:0] res_d_i,
   input  sa_flags_t         flags_d_i,
   output logic [DATA_W-1:0] res_q_o,
   output sa_flags_t         flags_q_o,
   output logic              sat_q_o
);
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         res_q_o   <= '0;
         flags_q_o <= '0;
         sat_q_o   <= 1'b0;
      end else begin
         if (fire_i) begin
            res_q_o   <= res_d_i;
            flags_q_o <= flags_d_i;
         end
         sat_q_o <= (sat_q_o & ~sat_clr_i) | (fire_i & flags_d_i.ov);
      end
   end

   AST_CLAMP_EXTREME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_q_o.ov |-> (res_q_o == POS_MAX || res_q_o == NEG_MIN)); // R2
   AST_OVF_RAISES_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_i && flags_d_i.ov) |=> (flags_q_o.ov && sat_q_o)); // R7
   AST_SAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sat_q_o && !sat_clr_i) |=> sat_q_o); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fire_i |=> ($stable(res_q_o) && $stable(flags_q_o))); // R8
   AST_CLEAN_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_i && !flags_d_i.ov) |=> !flags_q_o.ov); // R6
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
   import sat_arith_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SIMM_W       = 5,
   parameter int LIMM_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] reg_a_i,
   input  logic [DATA_W-1:0] reg_b_i,
   input  logic [LIMM_W-1:0] imm_i,
   input  logic              sat_clr_i,
   output logic [DATA_W-1:0] result_o,
   output logic              zero_o,
   output logic              sign_o,
   output logic              carry_o,
   output logic              ovf_o,
   output logic              sat_o
);
   initial begin : chk_params
      if (SIMM_W > LIMM_W)
         $fatal(1, "sat_arith_unit: SIMM_W must not exceed LIMM_W");
      if (LIMM_W >= DATA_W)
         $fatal(1, "sat_arith_unit: LIMM_W must be below DATA_W");
   end

   logic [DATA_W-1:0] simm_ext;
   logic [DATA_W-1:0] limm_ext;
   logic [DATA_W-1:0] opx;
   logic [DATA_W-1:0] opy;
   logic              is_sub;
   logic              legal;
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] sat_res;
   sa_flags_t         flags_d;
   sa_flags_t         flags_q;
   logic              fire;

   sa_imm_ext #(.IN_W(SIMM_W), .OUT_W(DATA_W)) u_simm (
      .imm_i (imm_i[SIMM_W-1:0]),
      .ext_o (simm_ext)
   );

   sa_imm_ext #(.IN_W(LIMM_W), .OUT_W(DATA_W)) u_limm (
      .imm_i (imm_i),
      .ext_o (limm_ext)
   );

   sa_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .op_i     (op_i),
      .reg_a_i  (reg_a_i),
      .reg_b_i  (reg_b_i),
      .simm_i   (simm_ext),
      .limm_i   (limm_ext),
      .x_o      (opx),
      .y_o      (opy),
      .is_sub_o (is_sub),
      .legal_o  (legal)
   );

   sa_addsub_core #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_core (
      .x_i       (opx),
      .y_i       (opy),
      .is_sub_i  (is_sub),
      .raw_o     (raw),
      .sat_res_o (sat_res),
      .flags_o   (flags_d)
   );

   assign fire = valid_i & legal;

   sa_status_reg #(.DATA_W(DATA_W)) u_stat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fire_i    (fire),
      .sat_clr_i (sat_clr_i),
      .res_d_i   (sat_res),
      .flags_d_i (flags_d),
      .res_q_o   (result_o),
      .flags_q_o (flags_q),
      .sat_q_o   (sat_o)
   );

   assign zero_o  = flags_q.z;
   assign sign_o  = flags_q.s;
   assign carry_o = flags_q.cy;
   assign ovf_o   = flags_q.ov;

   AST_Z_FROM_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && raw == '0) |=> zero_o); // R4
   AST_RESULT_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && !flags_d.ov) |=> (result_o == $past(raw))); // R1
endmodule

// File: tb/sat_arith_unit_tb_top.sv
`timescale 1ns/1ps
module sat_arith_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] ra = '0;
   logic [31:0] rb = '0;
   logic [15:0] imm = '0;
   logic        sclr = 1'b0;
   logic [31:0] result;
   logic        zf, sf, cf, of, satf;

   always #10 clk = ~clk;  // 50 MHz

   sat_arith_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
      .reg_a_i(ra), .reg_b_i(rb), .imm_i(imm), .sat_clr_i(sclr),
      .result_o(result), .zero_o(zf), .sign_o(sf), .carry_o(cf),
      .ovf_o(of), .sat_o(satf)
   );

   typedef struct {
      logic [31:0] res;
      logic        z, s, cy, ov, sat;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t st;
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   // Driver: applies one item per cycle and pushes the model's expectation.
   task automatic apply(input logic v, input logic [2:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im,
                        input logic clr, input string tag);
      logic [31:0] xv, yv;
      logic        sub;
      longint      xs, ys, r;
      logic [32:0] u;
      logic        ov;
      @(negedge clk);
      valid = v; op = o; ra = a; rb = b; imm = im; sclr = clr;
      sub = 1'b0; xv = a; yv = b;
      case (o)
         3'd0: begin xv = a; yv = b; end
         3'd1: begin xv = {{27{im[4]}}, im[4:0]}; yv = b; end
         3'd2: begin xv = b; yv = a; sub = 1'b1; end
         3'd3: begin xv = b; yv = {{16{im[15]}}, im}; sub = 1'b1; end
         3'd4: begin xv = a; yv = b; sub = 1'b1; end
         default: ;
      endcase
      st.sat = st.sat & ~clr;
      if (v && o <= 3'd4) begin
         xs = longint'($signed(xv));
         ys = longint'($signed(yv));
         r  = sub ? xs - ys : xs + ys;
         ov = (r > 64'sd2147483647) || (r < -64'sd2147483648);
         st.res = ov ? ((r > 0) ? 32'h7fff_ffff : 32'h8000_0000) : r[31:0];
         st.z   = (r[31:0] == 32'd0);
         st.s   = r[31];
         u      = {1'b0, xv} + {1'b0, yv};
         st.cy  = sub ? (yv > xv) : u[32];
         st.ov  = ov;
         st.sat = st.sat | ov;
      end
      st.tag = tag;
      exp_q.push_back(st);
   endtask

   // Monitor: compares one item per cycle, sampled after the falling edge.
   initial begin
      forever begin
         int   n;
         exp_t e;
         bit   bad;
         @(posedge clk);
         n = exp_q.size();
         @(negedge clk);
         #1;
         if (n > 0) begin
            e = exp_q.pop_front();
            bad = 1'b0;
            n_chk++;
            if (result !== e.res) begin
               bad = 1'b1;
               $display("FAIL %s result act %h exp %h", e.tag, result, e.res);
            end
            if (zf !== e.z || sf !== e.s) begin
               bad = 1'b1;
               $display("FAIL R4 (%s) z/s act %b%b exp %b%b", e.tag, zf, sf, e.z, e.s);
            end
            if (cf !== e.cy) begin
               bad = 1'b1;
               $display("FAIL R5 (%s) carry act %b exp %b", e.tag, cf, e.cy);
            end
            if (of !== e.ov) begin
               bad = 1'b1;
               $display("FAIL R6 (%s) ovf act %b exp %b", e.tag, of, e.ov);
            end
            if (satf !== e.sat) begin
               bad = 1'b1;
               $display("FAIL R7 (%s) sat act %b exp %b", e.tag, satf, e.sat);
            end
            if (bad) n_fail++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      st = '{res: 32'd0, z: 1'b0, s: 1'b0, cy: 1'b0, ov: 1'b0, sat: 1'b0, tag: ""};
      repeat (4) @(posedge clk);
      // R9: reset state, checked while reset is still applied
      @(negedge clk);
      n_chk++;
      if ({result, zf, sf, cf, of, satf} !== 37'd0) begin
         n_fail++;
         $display("FAIL R9 reset outputs act %h exp 0", {result, zf, sf, cf, of, satf});
      end
      rst_n = 1'b1;

      apply(1, 3'd0, 32'd7, 32'd5, 16'd0, 0, "R1 add rr");
      apply(1, 3'd2, 32'd9, 32'd4, 16'd0, 0, "R1 sub b-a");
      apply(1, 3'd4, 32'd9, 32'd4, 16'd0, 0, "R1 rsub a-b");
      apply(1, 3'd3, 32'd0, 32'd100, 16'd30, 0, "R1 sub imm");
      apply(1, 3'd0, 32'd1, 32'h7fff_ffff, 16'd0, 0, "R2 max+1");
      apply(1, 3'd0, 32'hffff_ffff, 32'h8000_0000, 16'd0, 0, "R2 min+neg");
      apply(1, 3'd2, 32'd1, 32'h8000_0000, 16'd0, 0, "R3 min-1");
      apply(1, 3'd4, 32'h7fff_ffff, 32'hffff_ffff, 16'd0, 0, "R3 rsub max-(-1)");
      apply(1, 3'd1, 32'd0, 32'd5, 16'h0a10, 0, "R10 imm5 -16 upper ignored");
      apply(1, 3'd1, 32'd0, 32'd5, 16'h001b, 0, "R4 zero via imm5 -5");
      apply(1, 3'd3, 32'd0, 32'h7fff_ffff, 16'h8000, 0, "R10 imm16 0x8000 overflow");
      apply(1, 3'd3, 32'd0, 32'd0, 16'h8000, 0, "R5 borrow 0-imm16");
      apply(1, 3'd2, 32'd3, 32'd3, 16'd0, 0, "R7 sat stays after clean op");
      apply(0, 3'd0, 32'h1234, 32'h5678, 16'd0, 0, "R8 valid low holds");
      apply(1, 3'd6, 32'h1234, 32'h5678, 16'd0, 0, "R8 illegal code holds");
      apply(0, 3'd0, 32'd0, 32'd0, 16'd0, 1, "R7 standalone clear");
      apply(1, 3'd0, 32'd1, 32'h7fff_ffff, 16'd0, 1, "R7 clear with overflow");
      apply(1, 3'd7, 32'd0, 32'd0, 16'd0, 1, "R8 illegal with clear");

      for (int i = 0; i < 600; i++) begin
         logic [2:0] o;
         o = 3'($urandom_range(0, 7));
         apply(($urandom_range(0, 7) != 0), o, $urandom, $urandom,
               16'($urandom), ($urandom_range(0, 15) == 0), "R1 random");
      end

      @(negedge clk);
      valid = 1'b0; sclr = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule